// File: doc/BRIEF.md
# Two-Level Page Translation Cache

This block turns a page number carried by an incoming remote request into the local page number that the memory side understands. It keeps recent translations in two levels. The first is a small, fully associative store that answers quickly. The second is a larger two-way set-associative store with least-recently-used replacement that answers a little later. A lookup tries the first level, then the second on a first-level miss. On a second-level miss it answers "miss" and hands the request to an external page walker.

Requests arrive on a valid/ready port with a tag and a page number. The block handles one lookup at a time. Each response is a single-cycle pulse that carries the request's tag, a hit flag and the translated page number. A miss also pulses the walker port with the same tag and page number. The walker later returns the translation on the fill port, and the fill writes it into both levels. The invalidate port removes one page from both levels, or every entry at once. First-level and second-level lookup latencies are parameters.

Top module: `xlat_tlb2`

## Requirements
- R1: `req_ready` is high exactly when no lookup is in progress. A request accepted on an edge drops `req_ready` for the next cycle. `req_ready` is high again in the cycle in which the response is presented.
- R2: When the page is held in the first level, the response appears `L1_LAT` cycles after the accepting edge, with `resp_hit`=1 and the stored local page number.
- R3: When the first level misses and the second level holds the page, the response appears `L1_LAT+L2_LAT` cycles after the accepting edge, with `resp_hit`=1 and the stored local page number.
- R4: When both levels miss, the response appears `L1_LAT+L2_LAT` cycles after acceptance, with `resp_hit`=0 and `resp_spn`=0. `walk_valid` pulses in the same cycle, carrying the request's tag and page number.
- R5: A fill writes the page into the first level. A page already present there is overwritten in place. Otherwise the fill goes to the slot under a round-robin pointer, and that pointer then advances by one.
- R6: The second-level set index is the low `L2_SET_BITS` bits of the page number. A fill reuses the way that already holds the page. Failing that, it takes an invalid way, way 0 before way 1. Failing that, it takes the least-recently-used way. Both a second-level hit and a fill make the used way the most recently used.
- R7: An invalidate with `inv_all`=0 removes `inv_epn` from both levels, so a later lookup of that page goes to the walker. Other pages stay.
- R8: An invalidate with `inv_all`=1 removes every entry in both levels.
- R9: A fill of the page under lookup, arriving on the edge where a level is evaluated, makes that level hit with the filled value. An invalidate of that page on that edge, without such a fill, makes that level miss. When a fill and an invalidate of the same page arrive on the same edge, the fill takes precedence.
- R10: Every response carries the tag of the request it answers. `resp_valid` and `walk_valid` are single-cycle pulses.
- R11: After reset both levels are empty, `req_ready` is high, and `resp_valid` and `walk_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup |
| req_tag | input | TAG_W | Request identifier |
| req_epn | input | EPN_W | Remote page number to translate |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | Translation found |
| resp_tag | output | TAG_W | Tag of the answered request |
| resp_spn | output | SPN_W | Local page number, zero on a miss |
| walk_valid | output | 1 | Miss handed to the walker |
| walk_tag | output | TAG_W | Tag of the missed request |
| walk_epn | output | EPN_W | Page number for the walker to resolve |
| fill_valid | input | 1 | Walker returns a translation |
| fill_epn | input | EPN_W | Remote page number of the fill |
| fill_spn | input | SPN_W | Local page number of the fill |
| inv_valid | input | 1 | Invalidate request |
| inv_all | input | 1 | Invalidate every entry instead of one page |
| inv_epn | input | EPN_W | Page to invalidate |

## Verification
The bench builds the block with a four-entry first level, four second-level sets (eight entries), 16-bit remote and 12-bit local page numbers, a first-level latency of 1 and a second-level latency of 3. With so few slots, a handful of fills wraps the round-robin pointer and fills both ways of a set. First-level eviction, second-level LRU victim choice and the difference between the two hit latencies can therefore be seen with directed sequences. A random phase over a 24-page address space then mixes lookups, fills and invalidates, so same-edge fill and invalidate collisions occur many times.

// File: rtl/xlat_tlb2.sv
module xlat_tlb2 #(
  parameter int EPN_W       = 28,
  parameter int SPN_W       = 24,
  parameter int TAG_W       = 6,
  parameter int L1_ENTRIES  = 32,
  parameter int L2_SET_BITS = 8,
  parameter int L1_LAT      = 1,
  parameter int L2_LAT      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [EPN_W-1:0] req_epn,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic [TAG_W-1:0] resp_tag,
  output logic [SPN_W-1:0] resp_spn,
  output logic             walk_valid,
  output logic [TAG_W-1:0] walk_tag,
  output logic [EPN_W-1:0] walk_epn,
  input  logic             fill_valid,
  input  logic [EPN_W-1:0] fill_epn,
  input  logic [SPN_W-1:0] fill_spn,
  input  logic             inv_valid,
  input  logic             inv_all,
  input  logic [EPN_W-1:0] inv_epn
);
  localparam int L1_IW   = $clog2(L1_ENTRIES);
  localparam int L2_SETS = 1 << L2_SET_BITS;
  localparam int L2_TW   = EPN_W - L2_SET_BITS;
  localparam int MAXLAT  = (L1_LAT > L2_LAT) ? L1_LAT : L2_LAT;
  localparam int CNT_W   = $clog2(MAXLAT + 1);

  typedef enum logic [1:0] {IDLE, PROBE1, PROBE2} state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic [EPN_W-1:0]   cur_epn;
  logic [TAG_W-1:0]   cur_tag;

  logic [L1_ENTRIES-1:0] l1_v;
  logic [EPN_W-1:0]      l1_e [L1_ENTRIES];
  logic [SPN_W-1:0]      l1_s [L1_ENTRIES];
  logic [L1_IW-1:0]      l1_rr;

  logic [1:0]         l2_v [L2_SETS];
  logic [L2_TW-1:0]   l2_t [L2_SETS][2];
  logic [SPN_W-1:0]   l2_s [L2_SETS][2];
  logic [L2_SETS-1:0] l2_lru;

  logic             l1_arr_hit, f1_match;
  logic [SPN_W-1:0] l1_arr_spn;
  logic [L1_IW-1:0] f1_idx;

  always_comb begin
    l1_arr_hit = 1'b0;
    l1_arr_spn = '0;
    f1_match   = 1'b0;
    f1_idx     = l1_rr;
    for (int i = 0; i < L1_ENTRIES; i++) begin
      if (l1_v[i] && l1_e[i] == cur_epn) begin
        l1_arr_hit = 1'b1;
        l1_arr_spn = l1_s[i];
      end
      if (l1_v[i] && l1_e[i] == fill_epn) begin
        f1_match = 1'b1;
        f1_idx   = L1_IW'(i);
      end
    end
  end

  wire [L2_SET_BITS-1:0] cur_set = cur_epn[L2_SET_BITS-1:0];
  wire [L2_TW-1:0]       cur_tg  = cur_epn[EPN_W-1:L2_SET_BITS];
  wire l2_h0 = l2_v[cur_set][0] && l2_t[cur_set][0] == cur_tg;
  wire l2_h1 = l2_v[cur_set][1] && l2_t[cur_set][1] == cur_tg;
  wire [SPN_W-1:0] l2_arr_spn = l2_h1 ? l2_s[cur_set][1] : l2_s[cur_set][0];

  wire [L2_SET_BITS-1:0] fset = fill_epn[L2_SET_BITS-1:0];
  wire [L2_TW-1:0]       ftg  = fill_epn[EPN_W-1:L2_SET_BITS];
  wire fm0 = l2_v[fset][0] && l2_t[fset][0] == ftg;
  wire fm1 = l2_v[fset][1] && l2_t[fset][1] == ftg;
  wire fway = fm0 ? 1'b0 : fm1 ? 1'b1 : !l2_v[fset][0] ? 1'b0 :
              !l2_v[fset][1] ? 1'b1 : l2_lru[fset];

  wire [L2_SET_BITS-1:0] iset = inv_epn[L2_SET_BITS-1:0];
  wire [L2_TW-1:0]       itg  = inv_epn[EPN_W-1:L2_SET_BITS];

  wire fill_same = fill_valid && fill_epn == cur_epn;
  wire inv_kill  = inv_valid && (inv_all || inv_epn == cur_epn);
  wire last1     = state == PROBE1 && cnt == CNT_W'(L1_LAT - 1);
  wire last2     = state == PROBE2 && cnt == CNT_W'(L2_LAT - 1);
  wire hit1      = fill_same || (!inv_kill && l1_arr_hit);
  wire hit2      = fill_same || (!inv_kill && (l2_h0 || l2_h1));
  wire touch     = last2 && !fill_same && !inv_kill && (l2_h0 || l2_h1);
  wire [SPN_W-1:0] spn1 = fill_same ? fill_spn : l1_arr_spn;
  wire [SPN_W-1:0] spn2 = fill_same ? fill_spn : l2_arr_spn;

  assign req_ready = state == IDLE;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= IDLE;
      cnt        <= '0;
      cur_epn    <= '0;
      cur_tag    <= '0;
      l1_v       <= '0;
      l1_rr      <= '0;
      l2_lru     <= '0;
      for (int s = 0; s < L2_SETS; s++) l2_v[s] <= 2'b00;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_tag   <= '0;
      resp_spn   <= '0;
      walk_valid <= 1'b0;
      walk_tag   <= '0;
      walk_epn   <= '0;
    end else begin
      resp_valid <= 1'b0;
      walk_valid <= 1'b0;
      case (state)
        IDLE: if (req_valid) begin
          cur_epn <= req_epn;
          cur_tag <= req_tag;
          cnt     <= '0;
          state   <= PROBE1;
        end
        PROBE1: if (last1) begin
          cnt <= '0;
          if (hit1) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_tag   <= cur_tag;
            resp_spn   <= spn1;
            state      <= IDLE;
          end else begin
            state <= PROBE2;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        PROBE2: if (last2) begin
          resp_valid <= 1'b1;
          resp_hit   <= hit2;
          resp_tag   <= cur_tag;
          resp_spn   <= hit2 ? spn2 : '0;
          walk_valid <= !hit2;
          walk_tag   <= cur_tag;
          walk_epn   <= cur_epn;
          cnt        <= '0;
          state      <= IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= IDLE;
      endcase

      if (touch) l2_lru[cur_set] <= l2_h0;

      if (inv_valid) begin
        if (inv_all) begin
          l1_v <= '0;
          for (int s = 0; s < L2_SETS; s++) l2_v[s] <= 2'b00;
        end else begin
          for (int i = 0; i < L1_ENTRIES; i++)
            if (l1_e[i] == inv_epn) l1_v[i] <= 1'b0;
          for (int w = 0; w < 2; w++)
            if (l2_t[iset][w] == itg) l2_v[iset][w] <= 1'b0;
        end
      end

      if (fill_valid) begin
        l1_v[f1_idx] <= 1'b1;
        l1_e[f1_idx] <= fill_epn;
        l1_s[f1_idx] <= fill_spn;
        if (!f1_match) l1_rr <= l1_rr + 1'b1;
        l2_v[fset][fway] <= 1'b1;
        l2_t[fset][fway] <= ftg;
        l2_s[fset][fway] <= fill_spn;
        l2_lru[fset]     <= ~fway;
      end
    end
  end
endmodule

// File: rtl/xlat_tlb2_chk.sv
module xlat_tlb2_chk #(
  parameter int TAG_W  = 6,
  parameter int SPN_W  = 24,
  parameter int L1_LAT = 1,
  parameter int L2_LAT = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [TAG_W-1:0] req_tag,
  input logic             resp_valid,
  input logic             resp_hit,
  input logic [TAG_W-1:0] resp_tag,
  input logic [SPN_W-1:0] resp_spn,
  input logic             walk_valid,
  input logic [TAG_W-1:0] walk_tag
);
  logic [15:0]      age;
  logic [TAG_W-1:0] held_tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      age      <= '0;
      held_tag <= '0;
    end else if (req_valid && req_ready) begin
      age      <= 16'd1;
      held_tag <= req_tag;
    end else if (resp_valid) begin
      age <= '0;
    end else if (age != 16'd0) begin
      age <= age + 16'd1;
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);                                   // R1
  AST_READY_WITH_RESP: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> req_ready);                                                // R1
  AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (age == 16'(L1_LAT + 1) || age == 16'(L1_LAT + L2_LAT + 1))); // R3
  AST_WALK_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    walk_valid |-> resp_valid && !resp_hit);                                  // R4
  AST_MISS_ZERO_SPN: assert property (@(posedge clk) disable iff (rst)
    resp_valid && !resp_hit |-> resp_spn == '0 && walk_valid);                // R4
  AST_TAG_ECHO: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> resp_tag == held_tag);                                     // R10
  AST_WALK_TAG_ECHO: assert property (@(posedge clk) disable iff (rst)
    walk_valid |-> walk_tag == held_tag);                                     // R10
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);                                              // R10
endmodule

bind xlat_tlb2 xlat_tlb2_chk #(
  .TAG_W(TAG_W), .SPN_W(SPN_W), .L1_LAT(L1_LAT), .L2_LAT(L2_LAT)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_tag(req_tag), .resp_valid(resp_valid), .resp_hit(resp_hit),
  .resp_tag(resp_tag), .resp_spn(resp_spn), .walk_valid(walk_valid),
  .walk_tag(walk_tag)
);

// File: tb/xlat_tlb2_test.sv
module xlat_tlb2_test;
  localparam int EW = 16, SW = 12, TW = 4, L1N = 4, SB = 2, NS = 4, L1L = 1, L2L = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_ready;
  logic [TW-1:0] req_tag = '0;
  logic [EW-1:0] req_epn = '0;
  logic resp_valid, resp_hit, walk_valid;
  logic [TW-1:0] resp_tag, walk_tag;
  logic [SW-1:0] resp_spn;
  logic [EW-1:0] walk_epn;
  logic fill_valid = 0, inv_valid = 0, inv_all = 0;
  logic [EW-1:0] fill_epn = '0, inv_epn = '0;
  logic [SW-1:0] fill_spn = '0;

  xlat_tlb2 #(.EPN_W(EW), .SPN_W(SW), .TAG_W(TW), .L1_ENTRIES(L1N),
              .L2_SET_BITS(SB), .L1_LAT(L1L), .L2_LAT(L2L)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_tag(req_tag), .req_epn(req_epn), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .resp_tag(resp_tag), .resp_spn(resp_spn),
    .walk_valid(walk_valid), .walk_tag(walk_tag), .walk_epn(walk_epn),
    .fill_valid(fill_valid), .fill_epn(fill_epn), .fill_spn(fill_spn),
    .inv_valid(inv_valid), .inv_all(inv_all), .inv_epn(inv_epn));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input string rq, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, got, exp);
    end
  endtask

  // behavioural reference
  int ms, mc, mrr;
  logic [EW-1:0] me;
  logic [TW-1:0] mt;
  logic mv1 [L1N];
  logic [EW-1:0] me1 [L1N];
  logic [SW-1:0] ms1 [L1N];
  logic mv2 [NS][2];
  logic [EW-1:0] me2 [NS][2];
  logic [SW-1:0] ms2 [NS][2];
  int mlru [NS];
  logic x_rv = 0, x_hit = 0, x_wv = 0;
  logic [TW-1:0] x_tag = '0;
  logic [SW-1:0] x_spn = '0;
  logic [EW-1:0] x_wepn = '0;
  string x_lbl = "R10";

  always @(posedge clk) begin : model
    bit fsame, ikill, ahit, touch, f1m;
    int hw, tset, f1i, fset, fw;
    logic [SW-1:0] aspn;
    if (rst) begin
      ms = 0; mc = 0; mrr = 0; x_rv = 0; x_wv = 0; x_hit = 0;
      for (int i = 0; i < L1N; i++) mv1[i] = 0;
      for (int s = 0; s < NS; s++) begin mv2[s][0] = 0; mv2[s][1] = 0; mlru[s] = 0; end
    end else begin
      x_rv = 0; x_wv = 0; touch = 0; hw = 0; tset = 0; aspn = '0; ahit = 0;
      fsame = fill_valid && fill_epn == me;
      ikill = inv_valid && (inv_all || inv_epn == me);
      f1m = 0; f1i = mrr;
      for (int i = 0; i < L1N; i++)
        if (mv1[i] && me1[i] == fill_epn) begin f1m = 1; f1i = i; end
      fset = int'(fill_epn) % NS;
      if (mv2[fset][0] && me2[fset][0] == fill_epn) fw = 0;
      else if (mv2[fset][1] && me2[fset][1] == fill_epn) fw = 1;
      else if (!mv2[fset][0]) fw = 0;
      else if (!mv2[fset][1]) fw = 1;
      else fw = mlru[fset];
      case (ms)
        0: if (req_valid) begin me = req_epn; mt = req_tag; mc = 0; ms = 1; end
        1: if (mc == L1L - 1) begin
             for (int i = 0; i < L1N; i++)
               if (mv1[i] && me1[i] == me) begin ahit = 1; aspn = ms1[i]; end
             mc = 0;
             if (fsame || (!ikill && ahit)) begin
               x_rv = 1; x_hit = 1; x_tag = mt; x_spn = fsame ? fill_spn : aspn;
               x_lbl = fsame ? "R9" : "R2"; ms = 0;
             end else ms = 2;
           end else mc++;
        2: if (mc == L2L - 1) begin
             tset = int'(me) % NS;
             for (int w = 0; w < 2; w++)
               if (mv2[tset][w] && me2[tset][w] == me) begin ahit = 1; aspn = ms2[tset][w]; hw = w; end
             x_rv = 1; x_tag = mt; x_hit = fsame || (!ikill && ahit);
             x_spn = !x_hit ? '0 : fsame ? fill_spn : aspn;
             x_lbl = fsame ? "R9" : x_hit ? "R3" : "R4";
             if (!x_hit) begin x_wv = 1; x_wepn = me; end
             touch = !fsame && !ikill && ahit; mc = 0; ms = 0;
           end else mc++;
        default: ms = 0;
      endcase
      if (touch) mlru[tset] = 1 - hw;
      if (inv_valid) begin
        for (int i = 0; i < L1N; i++) if (inv_all || me1[i] == inv_epn) mv1[i] = 0;
        for (int s = 0; s < NS; s++)
          for (int w = 0; w < 2; w++) if (inv_all || me2[s][w] == inv_epn) mv2[s][w] = 0;
      end
      if (fill_valid) begin
        mv1[f1i] = 1; me1[f1i] = fill_epn; ms1[f1i] = fill_spn;
        if (!f1m) mrr = (mrr + 1) % L1N;
        mv2[fset][fw] = 1; me2[fset][fw] = fill_epn; ms2[fset][fw] = fill_spn;
        mlru[fset] = 1 - fw;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (req_ready !== (ms == 0)) begin
        errors++;
        $display("FAIL R1 ready: got %0b expected %0b", req_ready, ms == 0);
      end else if (resp_valid !== x_rv ||
                   (x_rv && (resp_hit !== x_hit || resp_tag !== x_tag || resp_spn !== x_spn))) begin
        errors++;
        $display("FAIL %s response: got v%0b h%0b t%0h s%0h expected v%0b h%0b t%0h s%0h",
                 x_rv ? x_lbl : "R10", resp_valid, resp_hit, resp_tag, resp_spn,
                 x_rv, x_hit, x_tag, x_spn);
      end else if (walk_valid !== x_wv || (x_wv && (walk_epn !== x_wepn || walk_tag !== x_tag))) begin
        errors++;
        $display("FAIL R4 walker: got v%0b e%0h t%0h expected v%0b e%0h t%0h",
                 walk_valid, walk_epn, walk_tag, x_wv, x_wepn, x_tag);
      end
    end
  end

  // mode 0 plain, 1 fill of same page at first-level evaluation edge, 2 invalidate there
  task automatic probe(input logic [EW-1:0] e, input logic [TW-1:0] t, input int mode,
                       input logic [SW-1:0] fs, output logic h, output logic [SW-1:0] s,
                       output int lat, output logic wv, output logic [EW-1:0] we,
                       output logic [TW-1:0] rt);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_epn = e; req_tag = t;
    @(negedge clk);
    req_valid = 0;
    repeat (L1L - 1) @(negedge clk);
    lat = L1L - 1;
    if (mode == 1) begin fill_valid = 1; fill_epn = e; fill_spn = fs; end
    if (mode == 2) begin inv_valid = 1; inv_all = 0; inv_epn = e; end
    do begin
      @(negedge clk);
      lat++;
      fill_valid = 0; inv_valid = 0;
    end while (!resp_valid && lat < 40);
    h = resp_hit; s = resp_spn; wv = walk_valid; we = walk_epn; rt = resp_tag;
  endtask

  task automatic fill(input logic [EW-1:0] e, input logic [SW-1:0] s);
    @(negedge clk);
    fill_valid = 1; fill_epn = e; fill_spn = s;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic inval(input logic [EW-1:0] e, input logic all);
    @(negedge clk);
    inv_valid = 1; inv_all = all; inv_epn = e;
    @(negedge clk);
    inv_valid = 0; inv_all = 0;
  endtask

  initial begin
    logic h, wv;
    logic [SW-1:0] s;
    logic [EW-1:0] we;
    logic [TW-1:0] rt;
    int lat;
    repeat (4) @(negedge clk);
    rst = 0;
    check("R11", "ready after reset", req_ready, 1);
    check("R11", "resp_valid after reset", resp_valid, 0);
    check("R11", "walk_valid after reset", walk_valid, 0);

    probe(16'h10, 4'd3, 0, '0, h, s, lat, wv, we, rt);
    check("R4", "cold hit", h, 0);
    check("R4", "miss latency", lat, L1L + L2L);
    check("R4", "walk pulse", wv, 1);
    check("R4", "walk page", we, 16'h10);
    check("R10", "miss tag", rt, 3);
    check("R4", "miss spn", s, 0);

    fill(16'h10, 12'h310);
    probe(16'h10, 4'd5, 0, '0, h, s, lat, wv, we, rt);
    check("R2", "first-level hit", h, 1);
    check("R2", "first-level latency", lat, L1L);
    check("R2", "first-level spn", s, 12'h310);
    check("R10", "hit tag", rt, 5);

    fill(16'h21, 12'h321); fill(16'h32, 12'h332);
    fill(16'h43, 12'h343); fill(16'h54, 12'h354);
    probe(16'h10, 4'd6, 0, '0, h, s, lat, wv, we, rt);
    check("R3", "second-level hit", h, 1);
    check("R3", "second-level latency", lat, L1L + L2L);
    check("R3", "second-level spn", s, 12'h310);

    fill(16'h64, 12'h364); fill(16'h71, 12'h371);
    fill(16'h82, 12'h382); fill(16'h93, 12'h393);
    probe(16'h54, 4'd7, 0, '0, h, s, lat, wv, we, rt);
    check("R6", "LRU victim gone", h, 0);
    probe(16'h10, 4'd8, 0, '0, h, s, lat, wv, we, rt);
    check("R6", "recently used way kept", h, 1);
    check("R6", "kept way latency", lat, L1L + L2L);

    fill(16'h64, 12'h555);
    fill(16'hA1, 12'h3A1);
    probe(16'h71, 4'd9, 0, '0, h, s, lat, wv, we, rt);
    check("R5", "in-place refill kept pointer", lat, L1L);
    check("R5", "in-place refill kept entry", h, 1);
    probe(16'h64, 4'd10, 0, '0, h, s, lat, wv, we, rt);
    check("R5", "refilled value", s, 12'h555);
    check("R5", "refilled latency", lat, L1L + L2L);

    inval(16'h71, 0);
    probe(16'h71, 4'd11, 0, '0, h, s, lat, wv, we, rt);
    check("R7", "invalidated page misses", h, 0);
    check("R7", "invalidated page walks", wv, 1);
    probe(16'h82, 4'd12, 0, '0, h, s, lat, wv, we, rt);
    check("R7", "other page kept", h, 1);
    check("R7", "other page latency", lat, L1L);

    probe(16'hB2, 4'd13, 1, 12'h6B2, h, s, lat, wv, we, rt);
    check("R9", "forwarded fill hit", h, 1);
    check("R9", "forwarded fill latency", lat, L1L);
    check("R9", "forwarded fill spn", s, 12'h6B2);
    probe(16'h82, 4'd14, 2, '0, h, s, lat, wv, we, rt);
    check("R9", "same-edge invalidate hit", h, 0);
    check("R9", "same-edge invalidate latency", lat, L1L + L2L);

    inval(16'h0, 1);
    probe(16'hB2, 4'd1, 0, '0, h, s, lat, wv, we, rt);
    check("R8", "flush first-level page", h, 0);
    probe(16'h10, 4'd2, 0, '0, h, s, lat, wv, we, rt);
    check("R8", "flush second-level page", h, 0);

    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      req_valid  = ($urandom % 2) == 0;
      req_epn    = EW'($urandom % 24);
      req_tag    = TW'($urandom);
      fill_valid = ($urandom % 4) == 0;
      fill_epn   = EW'($urandom % 24);
      fill_spn   = SW'($urandom);
      inv_valid  = ($urandom % 16) == 0;
      inv_all    = ($urandom % 8) == 0;
      inv_epn    = EW'($urandom % 24);
    end
    @(negedge clk);
    req_valid = 0; fill_valid = 0; inv_valid = 0; inv_all = 0;
    repeat (10) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog: got running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule